// File: doc/BRIEF.md
# Per-Core Interrupt Mask and Status Registers

This block fans a vector of level-sensitive interrupt request lines out to up to eight processor cores. Every core owns two registers in a small window of a control/status register space. One is a mask that software reads and writes, with one bit per source line. The other is a read-only status register that shows the current source levels. Each core gets one interrupt line. It is high when any source that is both active and unmasked for that core is present.

Source lines pass through a two-flop synchronizer before use. The status register shows the synchronized levels, so a device's request stays visible until the device drops its line. Software cannot clear it. A core's interrupt output is registered, one cycle after the synchronized level. Register reads are combinational from the address. Writes take effect at the clock edge where the write enable is high.

The window starts at 0x7C0. Core i's mask sits at 0x7C0 + 2*i and its status at 0x7C0 + 2*i + 1. Slots in the window for cores beyond the configured count read as zero and ignore writes.

Top module: `irq_route_regs`

## Requirements
- R1: The mask register of core i is at address 0x7C0 + 2*i. A write stores write-data bits [NUM_SRC-1:0], and a read returns them. Bits at NUM_SRC and above read as zero.
- R2: The status register of core i is at address 0x7C0 + 2*i + 1. Its bit k shows source line k as sampled through two flops: a change on a source line is visible after the second rising clock edge that follows it.
- R3: A write to any status address changes no mask register and no status bit.
- R4: A core's interrupt output is high one clock edge after the status bits ANDed with that core's mask are non-zero. It is low one edge after that AND is zero. With several mask bits set, any one active unmasked source raises it.
- R5: A source whose mask bit is clear for a core never raises that core's interrupt output, but it still shows in that core's status register.
- R6: A status bit stays set while its source line stays high, whatever software writes. It clears only when the source line drops, after the same two-edge delay.
- R7: After reset every mask register reads zero, every status register reads zero while the sources are low, and every interrupt output is low.
- R8: Addresses in the window 0x7C0..0x7CF that belong to a core index at or above NUM_CORES read as zero, and writes to them change no mask register.
- R9: Addresses outside the window read as zero, and writes to them change no mask register.
- R10: A write to one core's mask register leaves every other core's mask register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq_i | input | NUM_SRC | Level-sensitive interrupt request lines |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Write enable for the addressed register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the addressed register (combinational) |
| core_irq_o | output | NUM_CORES | Interrupt line of each core, registered |

## Verification
On every cycle, the checker confirms four things. The synchronized levels equal the source lines of two edges earlier. Each core's interrupt output follows its masked-status OR with one edge of delay. Writes to status, dead or out-of-window addresses leave all masks stable. Reads from dead or out-of-window addresses return zero. Other behaviour needs the directed scenarios to show it, because it depends on software-visible history. That covers mask read-back at each core's own address, independence of the cores' masks, the masking of high bits, and a status bit that survives software writes and clears only when its line falls.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int MAX_CORES = 8;
  localparam int MAX_SRC   = 32;
  localparam int WIN_SLOTS = 2 * MAX_CORES;

  // Distance of an address from the window base (wraps when below base).
  function automatic logic [31:0] win_offset(input logic [31:0] addr, input logic [31:0] base);
    return addr - base;
  endfunction

  function automatic logic win_hit(input logic [31:0] addr, input logic [31:0] base);
    return win_offset(addr, base) < 32'(WIN_SLOTS);
  endfunction

  // Core index owning a slot: two slots per core.
  function automatic logic [2:0] slot_core(input logic [31:0] addr, input logic [31:0] base);
    logic [31:0] off;
    off = win_offset(addr, base);
    return off[3:1];
  endfunction

  // Odd slot = status register, even slot = mask register.
  function automatic logic slot_is_status(input logic [31:0] addr, input logic [31:0] base);
    logic [31:0] off;
    off = win_offset(addr, base);
    return off[0];
  endfunction
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_route_pkg::*;
#(
  parameter int          NUM_CORES = 8,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] BASE_ADDR = 32'h7C0
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  output logic                 hit_o,
  output logic                 is_status_o,
  output logic                 dead_slot_o,
  output logic [NUM_CORES-1:0] core_sel_o,
  output logic [NUM_CORES-1:0] mask_we_o,
  output logic                 status_wr_o
);
  logic [31:0] addr32;
  logic [2:0]  core_idx;
  logic        core_ok;

  assign addr32      = 32'(addr_i);
  assign hit_o       = win_hit(addr32, BASE_ADDR);
  assign is_status_o = slot_is_status(addr32, BASE_ADDR);
  assign core_idx    = slot_core(addr32, BASE_ADDR);
  assign core_ok     = int'(core_idx) < NUM_CORES;
  assign dead_slot_o = hit_o && !core_ok;
  assign status_wr_o = we_i && hit_o && core_ok && is_status_o;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
    assign core_sel_o[c] = hit_o && (int'(core_idx) == c);
    assign mask_we_o[c]  = we_i && core_sel_o[c] && !is_status_o;
  end
endmodule

// File: rtl/irq_core_slice.sv
module irq_core_slice #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic [NUM_SRC-1:0] level_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic               irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      irq_q <= |(level_i & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int          NUM_CORES = 8,
  parameter int          NUM_SRC   = 32,
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h7C0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_irq_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_CORES-1:0] core_irq_o
);
  localparam int MASK_BITS = NUM_CORES * NUM_SRC;

  // Named internal events, brought out for the checker.
  logic [NUM_SRC-1:0]   sync_lvl;
  logic [MASK_BITS-1:0] en_flat;
  logic                 win_hit_w;
  logic                 is_status;
  logic                 dead_slot;
  logic                 status_wr;
  logic [NUM_CORES-1:0] core_sel;
  logic [NUM_CORES-1:0] mask_we;
  logic [NUM_SRC-1:0]   rd_field;

  irq_src_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_irq_i),
    .sync_o  (sync_lvl)
  );

  irq_reg_decode #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .addr_i      (reg_addr_i),
    .we_i        (reg_we_i),
    .hit_o       (win_hit_w),
    .is_status_o (is_status),
    .dead_slot_o (dead_slot),
    .core_sel_o  (core_sel),
    .mask_we_o   (mask_we),
    .status_wr_o (status_wr)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    irq_core_slice #(.NUM_SRC(NUM_SRC)) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .mask_we_i    (mask_we[c]),
      .mask_wdata_i (reg_wdata_i[NUM_SRC-1:0]),
      .level_i      (sync_lvl),
      .mask_o       (en_flat[c*NUM_SRC +: NUM_SRC]),
      .irq_o        (core_irq_o[c])
    );
  end

  if (DATA_W > NUM_SRC) begin : g_wdata_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_SRC];
  end

  always_comb begin
    rd_field = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (core_sel[c]) rd_field = is_status ? sync_lvl : en_flat[c*NUM_SRC +: NUM_SRC];
    end
    reg_rdata_o = '0;
    reg_rdata_o[NUM_SRC-1:0] = rd_field;
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_CORES = 8,
  parameter int NUM_SRC   = 32,
  parameter int DATA_W    = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_SRC-1:0]           src_irq_i,
  input logic                         reg_we_i,
  input logic [DATA_W-1:0]            reg_rdata_o,
  input logic [NUM_CORES-1:0]         core_irq_o,
  input logic [NUM_SRC-1:0]           sync_lvl,
  input logic [NUM_CORES*NUM_SRC-1:0] en_flat,
  input logic                         win_hit_w,
  input logic                         dead_slot,
  input logic                         status_wr
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (sync_lvl == $past(src_irq_i, 2)));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
    assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((sync_lvl & en_flat[c*NUM_SRC +: NUM_SRC]) != '0) |=> core_irq_o[c]);
    assert_irq_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((sync_lvl & en_flat[c*NUM_SRC +: NUM_SRC]) == '0) |=> !core_irq_o[c]);
  end

  assert_status_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> $stable(en_flat));

  assert_dead_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dead_slot |-> (reg_rdata_o == '0));

  assert_dead_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && dead_slot) |=> $stable(en_flat));

  assert_out_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit_w |-> (reg_rdata_o == '0));

  assert_out_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && !win_hit_w) |=> $stable(en_flat));
endmodule

bind irq_route_regs irq_route_chk #(
  .NUM_CORES (NUM_CORES),
  .NUM_SRC   (NUM_SRC),
  .DATA_W    (DATA_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_irq_i   (src_irq_i),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .core_irq_o  (core_irq_o),
  .sync_lvl    (sync_lvl),
  .en_flat     (en_flat),
  .win_hit_w   (win_hit_w),
  .dead_slot   (dead_slot),
  .status_wr   (status_wr)
);

// File: tb/irq_route_regs_tb_top.sv
module irq_route_regs_tb_top;
  localparam int NC   = 6;
  localparam int NS   = 20;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int BASE = 'h7C0;
  localparam logic [DW-1:0] SRC_MASK = DW'((64'd1 << NS) - 64'd1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [NC];

  always #5 clk = ~clk;

  irq_route_regs #(
    .NUM_CORES (NC),
    .NUM_SRC   (NS),
    .ADDR_W    (AW),
    .DATA_W    (DW),
    .BASE_ADDR (32'h7C0)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_irq_i   (src),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .core_irq_o  (irq)
  );

  // Address arithmetic restated independently of the design.
  function automatic logic [AW-1:0] mask_addr(input int core);
    return AW'(BASE + core * 2);
  endfunction
  function automatic logic [AW-1:0] stat_addr(input int core);
    return AW'(BASE + core * 2 + 1);
  endfunction

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all_masks(input string req);
    logic [DW-1:0] d;
    for (int c = 0; c < NC; c++) begin
      reg_read(mask_addr(c), d);
      check(req, $sformatf("mask core %0d", c), d, shadow[c]);
    end
  endtask

  task automatic t_reset_r7;
    logic [DW-1:0] d;
    for (int c = 0; c < NC; c++) begin
      shadow[c] = '0;
      reg_read(mask_addr(c), d);
      check("R7", "mask after reset", d, '0);
      reg_read(stat_addr(c), d);
      check("R7", "status after reset", d, '0);
    end
    check("R7", "irq after reset", DW'(irq), '0);
  endtask

  task automatic t_mask_rw_r1_r10;
    for (int c = 0; c < NC; c++) begin
      shadow[c] = (32'h5A3C1 * (c + 3)) & SRC_MASK;
      reg_write(mask_addr(c), (32'h5A3C1 * (c + 3)));
    end
    check_all_masks("R10");
    reg_write(mask_addr(0), 32'hFFFF_FFFF);
    shadow[0] = SRC_MASK;
    check_all_masks("R1");
    for (int c = 0; c < NC; c++) begin
      reg_write(mask_addr(c), '0);
      shadow[c] = '0;
    end
    check_all_masks("R1");
  endtask

  task automatic t_status_r2;
    logic [DW-1:0] d;
    @(negedge clk);
    src = NS'(20'hA5F0C);
    edges(1);
    reg_read(stat_addr(1), d);
    check("R2", "status after one edge", d, '0);
    edges(1);
    for (int c = 0; c < NC; c++) begin
      reg_read(stat_addr(c), d);
      check("R2", $sformatf("status core %0d", c), d, 32'hA5F0C);
    end
    check("R5", "no irq with masks clear", DW'(irq), '0);
    @(negedge clk);
    src = '0;
    edges(2);
  endtask

  task automatic t_irq_r4;
    reg_write(mask_addr(2), 32'h0000_0020);
    shadow[2] = 32'h20;
    reg_write(mask_addr(4), 32'h0000_0081);
    shadow[4] = 32'h81;
    @(negedge clk);
    src = NS'(20'h00020);
    edges(2);
    check("R4", "irq core2 before output edge", DW'(irq[2]), 0);
    edges(1);
    check("R4", "irq vector one edge later", DW'(irq), DW'(6'b000100));
    @(negedge clk);
    src = NS'(20'h00080);
    edges(3);
    check("R4", "OR of two mask bits", DW'(irq), DW'(6'b010000));
  endtask

  task automatic t_mask_r5;
    logic [DW-1:0] d;
    reg_write(mask_addr(4), 32'h0000_0001);
    shadow[4] = 32'h1;
    edges(1);
    check("R5", "masked source drops irq", DW'(irq), '0);
    reg_read(stat_addr(4), d);
    check("R5", "masked source still in status", d, 32'h80);
  endtask

  task automatic t_status_ro_r3_r6;
    logic [DW-1:0] d;
    reg_write(mask_addr(3), 32'h80);
    shadow[3] = 32'h80;
    edges(1);
    reg_write(stat_addr(3), '0);
    reg_write(stat_addr(0), 32'hFFFF_FFFF);
    reg_read(stat_addr(3), d);
    check("R6", "status survives writes", d, 32'h80);
    check("R3", "irq still high", DW'(irq[3]), 1);
    check_all_masks("R3");
    @(negedge clk);
    src = '0;
    edges(1);
    reg_read(stat_addr(3), d);
    check("R6", "status held one edge after drop", d, 32'h80);
    edges(1);
    reg_read(stat_addr(3), d);
    check("R6", "status clears after source drop", d, '0);
    edges(1);
    check("R6", "irq follows drop", DW'(irq), '0);
  endtask

  task automatic t_dead_r8;
    logic [DW-1:0] d;
    for (int c = NC; c < 8; c++) begin
      reg_write(mask_addr(c), 32'hFFFF_FFFF);
      reg_read(mask_addr(c), d);
      check("R8", "dead mask slot reads zero", d, '0);
      reg_read(stat_addr(c), d);
      check("R8", "dead status slot reads zero", d, '0);
    end
    check_all_masks("R8");
  endtask

  task automatic t_outside_r9;
    logic [DW-1:0] d;
    reg_write(AW'(BASE - 1), 32'hFFFF_FFFF);
    reg_write(AW'(BASE + 16), 32'hFFFF_FFFF);
    reg_write(AW'(BASE - 2), 32'hFFFF_FFFF);
    reg_read(AW'(BASE - 1), d);
    check("R9", "below window reads zero", d, '0);
    reg_read(AW'(BASE + 16), d);
    check("R9", "above window reads zero", d, '0);
    check_all_masks("R9");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges(1);
    t_reset_r7();
    t_mask_rw_r1_r10();
    t_status_r2();
    t_irq_r4();
    t_mask_r5();
    t_status_ro_r3_r6();
    t_dead_r8();
    t_outside_r9();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule